// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block decides which pending interrupt a small 8-bit processor core takes next and which 16-bit entry address it jumps to. It watches one non-maskable line, three maskable direct lines with fixed entry addresses, and one general request line whose entry address comes from an opcode supplied by the interrupting device. At each instruction boundary, signalled by a one-cycle `boundary` strobe, it samples the lines and applies a software mask and a global enable. It then picks a single winner by fixed priority and clears the global enable on entry.

For a direct winner the block presents the vector to the core at once. For a general-request winner it first raises an acknowledge and receives one opcode byte over a valid/ready channel. The byte is accepted on the cycle where `op_valid` and `op_ready` are both high. The device must hold `op_data` steady while `op_valid` is high and `op_ready` is low. A restart opcode (pattern `11nnn111`) becomes the table entry n×8. Any other byte is handed to the core as a call, with no table vector. Toward the core, `core_req` behaves like a valid signal and `core_accept` like its ready. The vector stays stable until it is accepted, and the block starts no new arbitration until the core pulses `core_done`.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset the mask bits are all 1 and the global enable is 0, so no maskable or general request is taken; `core_req`, `dev_ack` and `op_ready` are 0.
- R2: The non-maskable line, when high at a boundary while idle, is taken with vector 0024h whatever the mask and enable state.
- R3: The direct lines map to fixed vectors: `direct_in[0]` to 002Ch, `direct_in[1]` to 0034h, `direct_in[2]` to 003Ch.
- R4: Priority is non-maskable, then `direct_in[2]`, then `direct_in[1]`, then `direct_in[0]`, then the general request.
- R5: Mask bit i (bit 0 for `direct_in[0]`, up to bit 2) blocks direct line i when 1. A mask write (`mask_wr`) loads `mask_val` only when `mask_wen` is also 1. An edge held while its line is masked stays pending.
- R6: `direct_in[2]` is rising-edge sensitive. A rising edge stays pending until that line is serviced or a mask write with `edge_clr`=1 clears it. A level held high after servicing does not request again.
- R7: `direct_in[0]` and `direct_in[1]` are level sensitive and count only if high at the sampling boundary.
- R8: Taking any interrupt clears the global enable, so no further maskable or general request is taken until `ie_set` is pulsed. If `ie_set` and `ie_clr` arrive in the same cycle, `ie_clr` wins.
- R9: A general-request winner raises `dev_ack` and `op_ready` until an opcode is transferred. For an opcode matching `11nnn111` the vector is n×8 with `core_is_call`=0.
- R10: Any other opcode gives `core_is_call`=1, vector 0000h, and the byte on `core_opcode`.
- R11: Lines are sampled only on a `boundary` strobe while idle. Strobes during acknowledge, request or service are ignored.
- R12: `core_req` holds with a stable vector until `core_accept`, then drops. The block returns to idle only after `core_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| boundary | input | 1 | Instruction-boundary sampling strobe |
| nmi_in | input | 1 | Non-maskable request |
| direct_in | input | 3 | Direct maskable requests, bit 2 highest |
| gen_req_in | input | 1 | General request (device supplies opcode) |
| mask_wr | input | 1 | Mask-set operation strobe |
| mask_wen | input | 1 | Allows `mask_val` to load on `mask_wr` |
| mask_val | input | 3 | New mask bits, 1 = blocked |
| edge_clr | input | 1 | With `mask_wr`, discards a pending edge request |
| ie_set | input | 1 | Sets the global enable |
| ie_clr | input | 1 | Clears the global enable |
| dev_ack | output | 1 | Acknowledge to the general-request device |
| op_valid | input | 1 | Opcode byte valid from device |
| op_data | input | 8 | Opcode byte |
| op_ready | output | 1 | Block can take the opcode byte |
| core_req | output | 1 | Interrupt entry request to the core |
| core_vec | output | 16 | Entry vector address |
| core_is_call | output | 1 | Entry is a device-supplied call, not a table vector |
| core_opcode | output | 8 | Captured opcode byte (0 for direct entries) |
| core_accept | input | 1 | Core takes the request |
| core_done | input | 1 | Core has finished its entry sequence |

## Verification
The bench builds the block with its defaults: three direct lines with only the top one edge-latched, and 16-bit vectors. These defaults put every fixed vector and every restart slot within reach. They also cover the mixing of edge and level behaviour, where the edge latch must outlive both masking and a held-high level. Scenarios stress priority when several lines are high at once, and the lost-enable window after entry. They also exercise opcode back-pressure and strobes that arrive while an entry is still in progress.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACK,
    ST_REQ,
    ST_BUSY
  } ctl_state_e;

  localparam int unsigned NMI_VECTOR  = 'h24;
  localparam int unsigned DIRECT_BASE = 'h2C;
  localparam int unsigned DIRECT_STEP = 8;
  localparam int unsigned RESTART_STEP = 8;

  // Restart opcodes have the shape 11nnn111
  function automatic logic op_is_restart(input logic [7:0] op);
    return (op[7:6] == 2'b11) && (op[2:0] == 3'b111);
  endfunction

endpackage

// File: rtl/irq_input_stage.sv
module irq_input_stage #(
  parameter int unsigned N = 3,
  parameter logic [N-1:0] EDGE_MASK = 3'b100
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend
);

  for (genvar g = 0; g < N; g++) begin : g_line
    if (EDGE_MASK[g]) begin : g_edge
      logic prev_q;
      logic held_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          prev_q <= 1'b0;
          held_q <= 1'b0;
        end else begin
          prev_q <= raw[g];
          // a fresh edge beats a clear in the same cycle
          if (raw[g] && !prev_q) held_q <= 1'b1;
          else if (clr[g])       held_q <= 1'b0;
        end
      end
      assign pend[g] = held_q;
    end else begin : g_level
      logic unused_clr;
      assign unused_clr = clr[g];
      assign pend[g] = raw[g];
    end
  end

endmodule

// File: rtl/irq_enable_regs.sv
module irq_enable_regs #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mask_wr,
  input  logic         mask_wen,
  input  logic [N-1:0] mask_val,
  input  logic         ie_set,
  input  logic         ie_clr,
  input  logic         entry,
  output logic [N-1:0] mask_q,
  output logic         ie_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      ie_q   <= 1'b0;
    end else begin
      if (mask_wr && mask_wen) mask_q <= mask_val;
      if (entry || ie_clr) ie_q <= 1'b0;
      else if (ie_set)     ie_q <= 1'b1;
    end
  end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned N     = 3,
  parameter int unsigned VEC_W = 16
) (
  input  logic             nmi,
  input  logic [N-1:0]     pend,
  input  logic [N-1:0]     mask,
  input  logic             ie,
  input  logic             gen_req,
  output logic             win_valid,
  output logic             win_gen,
  output logic [N-1:0]     grant,
  output logic [VEC_W-1:0] win_vec
);

  logic [N-1:0] elig;
  assign elig = pend & ~mask & {N{ie}};

  always_comb begin
    win_valid = 1'b0;
    win_gen   = 1'b0;
    grant     = '0;
    win_vec   = '0;
    if (nmi) begin
      win_valid = 1'b1;
      win_vec   = VEC_W'(NMI_VECTOR);
    end else begin
      for (int i = N - 1; i >= 0; i--) begin
        if (!win_valid && elig[i]) begin
          win_valid = 1'b1;
          grant[i]  = 1'b1;
          win_vec   = VEC_W'(DIRECT_BASE + DIRECT_STEP * i);
        end
      end
      if (!win_valid && gen_req && ie) begin
        win_valid = 1'b1;
        win_gen   = 1'b1;
      end
    end
  end

endmodule

// File: rtl/irq_op_decode.sv
module irq_op_decode
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned VEC_W = 16
) (
  input  logic [7:0]       op,
  output logic             is_call,
  output logic [VEC_W-1:0] vec
);

  logic restart;
  assign restart = op_is_restart(op);
  assign is_call = !restart;
  assign vec     = restart ? VEC_W'(int'(op[5:3]) * RESTART_STEP) : '0;

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned N_DIRECT = 3,
  parameter int unsigned VEC_W    = 16,
  parameter logic [N_DIRECT-1:0] EDGE_MASK = 3'b100
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                boundary,
  input  logic                nmi_in,
  input  logic [N_DIRECT-1:0] direct_in,
  input  logic                gen_req_in,
  input  logic                mask_wr,
  input  logic                mask_wen,
  input  logic [N_DIRECT-1:0] mask_val,
  input  logic                edge_clr,
  input  logic                ie_set,
  input  logic                ie_clr,
  output logic                dev_ack,
  input  logic                op_valid,
  input  logic [7:0]          op_data,
  output logic                op_ready,
  output logic                core_req,
  output logic [VEC_W-1:0]    core_vec,
  output logic                core_is_call,
  output logic [7:0]          core_opcode,
  input  logic                core_accept,
  input  logic                core_done
);

  ctl_state_e state_q;
  logic [N_DIRECT-1:0] pend, mask_q, grant, line_clr;
  logic ie_q, win_valid, win_gen, entry, dec_call;
  logic [VEC_W-1:0] win_vec, dec_vec, vec_q;
  logic call_q;
  logic [7:0] op_q;

  assign entry    = (state_q == ST_IDLE) && boundary && win_valid;
  assign line_clr = (entry ? grant : '0) | {N_DIRECT{mask_wr & edge_clr}};

  irq_input_stage #(.N(N_DIRECT), .EDGE_MASK(EDGE_MASK)) u_inputs (
    .clk(clk), .rst_n(rst_n), .raw(direct_in), .clr(line_clr), .pend(pend)
  );

  irq_enable_regs #(.N(N_DIRECT)) u_enables (
    .clk(clk), .rst_n(rst_n), .mask_wr(mask_wr), .mask_wen(mask_wen),
    .mask_val(mask_val), .ie_set(ie_set), .ie_clr(ie_clr), .entry(entry),
    .mask_q(mask_q), .ie_q(ie_q)
  );

  irq_arbiter #(.N(N_DIRECT), .VEC_W(VEC_W)) u_arb (
    .nmi(nmi_in), .pend(pend), .mask(mask_q), .ie(ie_q), .gen_req(gen_req_in),
    .win_valid(win_valid), .win_gen(win_gen), .grant(grant), .win_vec(win_vec)
  );

  irq_op_decode #(.VEC_W(VEC_W)) u_dec (
    .op(op_data), .is_call(dec_call), .vec(dec_vec)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      vec_q   <= '0;
      call_q  <= 1'b0;
      op_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (entry) begin
          if (win_gen) state_q <= ST_ACK;
          else begin
            state_q <= ST_REQ;
            vec_q   <= win_vec;
            call_q  <= 1'b0;
            op_q    <= '0;
          end
        end
        ST_ACK: if (op_valid) begin
          state_q <= ST_REQ;
          vec_q   <= dec_vec;
          call_q  <= dec_call;
          op_q    <= op_data;
        end
        ST_REQ:  if (core_accept) state_q <= ST_BUSY;
        ST_BUSY: if (core_done)   state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign dev_ack      = (state_q == ST_ACK);
  assign op_ready     = (state_q == ST_ACK);
  assign core_req     = (state_q == ST_REQ);
  assign core_vec     = vec_q;
  assign core_is_call = call_q;
  assign core_opcode  = op_q;

endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk #(
  parameter int unsigned VEC_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             boundary,
  input logic             nmi_in,
  input logic             dev_ack,
  input logic             op_valid,
  input logic             core_req,
  input logic             core_accept,
  input logic [VEC_W-1:0] core_vec,
  input logic             core_is_call
);

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_req && !core_accept |=> core_req && $stable(core_vec) && $stable(core_is_call));

  // R12
  req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_req && core_accept |=> !core_req);

  // R9
  ack_to_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_ack && op_valid |=> core_req && !dev_ack);

  // R10
  call_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_req && core_is_call |-> core_vec == '0);

  // R3
  table_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_req && !core_is_call |-> core_vec[1:0] == 2'b00 && core_vec[VEC_W-1:6] == '0);

  // R2
  nmi_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_req) && $past(boundary && nmi_in && !dev_ack) |-> core_vec == VEC_W'('h24));

endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(.VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .boundary(boundary), .nmi_in(nmi_in),
  .dev_ack(dev_ack), .op_valid(op_valid), .core_req(core_req),
  .core_accept(core_accept), .core_vec(core_vec), .core_is_call(core_is_call)
);

// File: tb/test_irq_vector_ctrl.sv
module test_irq_vector_ctrl;

  logic clk = 1'b0, rst_n = 1'b0;
  logic boundary = 0, nmi_in = 0, gen_req_in = 0;
  logic [2:0] direct_in = '0, mask_val = '0;
  logic mask_wr = 0, mask_wen = 0, edge_clr = 0, ie_set = 0, ie_clr = 0;
  logic op_valid = 0, core_accept = 0, core_done = 0;
  logic [7:0] op_data = '0;
  logic dev_ack, op_ready, core_req, core_is_call;
  logic [15:0] core_vec;
  logic [7:0] core_opcode;

  int checks = 0, fails = 0, cycles = 0;
  bit done_flag = 0;

  always #10 clk = ~clk;

  irq_vector_ctrl i_irq_vector_ctrl (
    .clk(clk), .rst_n(rst_n), .boundary(boundary), .nmi_in(nmi_in),
    .direct_in(direct_in), .gen_req_in(gen_req_in), .mask_wr(mask_wr),
    .mask_wen(mask_wen), .mask_val(mask_val), .edge_clr(edge_clr),
    .ie_set(ie_set), .ie_clr(ie_clr), .dev_ack(dev_ack), .op_valid(op_valid),
    .op_data(op_data), .op_ready(op_ready), .core_req(core_req),
    .core_vec(core_vec), .core_is_call(core_is_call), .core_opcode(core_opcode),
    .core_accept(core_accept), .core_done(core_done)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic report();
    if (!done_flag) begin
      done_flag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // behavioural reference: phase 0 idle, 1 opcode wait, 2 offered, 3 in service
  int m_phase, m_vec, m_op;
  bit m_call, m_ie, m_seen_edge, m_last_top;
  bit [2:0] m_mask;
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_phase = 0; m_vec = 0; m_op = 0; m_call = 0;
      m_ie = 0; m_seen_edge = 0; m_last_top = 0; m_mask = 3'b111;
    end else begin
      bit took, to_ack, drop_edge;
      int nv;
      took = 0; to_ack = 0; drop_edge = 0; nv = 0;
      if (m_phase == 0 && boundary) begin
        if (nmi_in) begin took = 1; nv = 'h24; end
        else if (m_ie && m_seen_edge && !m_mask[2]) begin took = 1; nv = 'h3C; drop_edge = 1; end
        else if (m_ie && direct_in[1] && !m_mask[1]) begin took = 1; nv = 'h34; end
        else if (m_ie && direct_in[0] && !m_mask[0]) begin took = 1; nv = 'h2C; end
        else if (m_ie && gen_req_in) begin took = 1; to_ack = 1; end
      end
      case (m_phase)
        0: if (took) begin
             if (to_ack) m_phase = 1;
             else begin m_phase = 2; m_vec = nv; m_call = 0; m_op = 0; end
           end
        1: if (op_valid) begin
             m_phase = 2; m_op = op_data;
             if (op_data[7:6] == 2'b11 && op_data[2:0] == 3'b111) begin
               m_vec = ((op_data >> 3) % 8) * 8; m_call = 0;
             end else begin
               m_vec = 0; m_call = 1;
             end
           end
        2: if (core_accept) m_phase = 3;
        default: if (core_done) m_phase = 0;
      endcase
      if (mask_wr && mask_wen) m_mask = mask_val;
      if (drop_edge || (mask_wr && edge_clr)) m_seen_edge = 0;
      if (direct_in[2] && !m_last_top) m_seen_edge = 1;
      if (took || ie_clr) m_ie = 0; else if (ie_set) m_ie = 1;
      m_last_top = direct_in[2];
    end
  end

  always @(negedge clk) begin
    chk(core_req == (m_phase == 2), "R12", "model core_req", core_req, m_phase == 2);
    chk(dev_ack == (m_phase == 1) && op_ready == (m_phase == 1), "R9",
        "model dev_ack/op_ready", {dev_ack, op_ready}, {2{m_phase == 1}});
    if (m_phase == 2) begin
      chk(core_vec == m_vec, "R4", "model core_vec", core_vec, m_vec);
      chk(core_is_call == m_call && core_opcode == m_op, "R10", "model call/opcode",
          {core_is_call, core_opcode}, {m_call, m_op[7:0]});
    end
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      report();
    end
  end

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic sample();
    boundary = 1; step(); boundary = 0;
  endtask

  task automatic enable();
    ie_set = 1; step(); ie_set = 0;
  endtask

  task automatic write_mask(input bit wen, input bit [2:0] v, input bit clr);
    mask_wr = 1; mask_wen = wen; mask_val = v; edge_clr = clr;
    step();
    mask_wr = 0; mask_wen = 0; edge_clr = 0;
  endtask

  task automatic expect_take(input int v, input bit call, input int op,
                             input string tag, input int hold = 0);
    chk(core_req == 1, tag, "core_req", core_req, 1);
    chk(core_vec == v, tag, "core_vec", core_vec, v);
    chk(core_is_call == call && core_opcode == op, tag, "call/opcode",
        {core_is_call, core_opcode}, {call, op[7:0]});
    for (int k = 0; k < hold; k++) begin
      step();
      chk(core_req == 1 && core_vec == v, "R12", "held offer", core_vec, v);
    end
    core_accept = 1; step(); core_accept = 0;
    chk(core_req == 0, "R12", "drop after accept", core_req, 0);
    step(2);
    core_done = 1; step(); core_done = 0;
  endtask

  task automatic expect_none(input string tag);
    step();
    chk(core_req == 0 && dev_ack == 0, tag, "no entry", {core_req, dev_ack}, 0);
  endtask

  initial begin
    step(3);
    chk(core_req == 0 && dev_ack == 0 && op_ready == 0, "R1", "reset outputs",
        {core_req, dev_ack, op_ready}, 0);
    rst_n = 1; step();
    // R1: all lines high right after reset, nothing maskable taken
    direct_in = 3'b111; gen_req_in = 1; step();
    sample(); expect_none("R1");
    gen_req_in = 0;
    // R2: non-maskable bypasses mask and disabled enable
    nmi_in = 1; sample(); nmi_in = 0;
    expect_take('h24, 0, 0, "R2");
    // R5: mask write without its enable bit is dropped
    write_mask(0, 3'b000, 0); enable();
    sample(); expect_none("R5");
    write_mask(1, 3'b000, 0);
    // R4: latched top edge wins over the two levels
    sample(); expect_take('h3C, 0, 0, "R4");
    // R8: enable was cleared on entry
    sample(); expect_none("R8");
    // R6: top line still high, no new edge, so the middle line wins
    enable(); sample(); expect_take('h34, 0, 0, "R6");
    // R3 / R7: lowest direct line
    direct_in = 3'b101; enable(); sample(); expect_take('h2C, 0, 0, "R3");
    // R4: non-maskable beats everything
    direct_in = 3'b111; nmi_in = 1; enable(); sample(); nmi_in = 0;
    expect_take('h24, 0, 0, "R4");
    // R7: levels low at the boundary are not taken
    direct_in = 3'b100; enable(); sample(); expect_none("R7");
    // R6: short pulse on the top line is remembered
    direct_in = 3'b000; step(); direct_in = 3'b100; step(); direct_in = 3'b000; step(2);
    sample(); expect_take('h3C, 0, 0, "R6");
    // R6: software clear discards a pending edge
    direct_in = 3'b100; step(); direct_in = 3'b000;
    write_mask(0, 3'b000, 1); enable(); sample(); expect_none("R6");
    // R5: masked top edge stays pending, lower line served meanwhile
    direct_in = 3'b100; step(); direct_in = 3'b010;
    write_mask(1, 3'b100, 0); enable(); sample();
    expect_take('h34, 0, 0, "R5");
    direct_in = 3'b000; write_mask(1, 3'b000, 0); enable(); sample();
    expect_take('h3C, 0, 0, "R5");
    // R9: general request with back-pressure, restart opcode
    gen_req_in = 1; enable(); sample(); gen_req_in = 0;
    chk(dev_ack && op_ready && !core_req, "R9", "ack raised", {dev_ack, op_ready, core_req}, 6);
    step(3);
    chk(dev_ack && op_ready, "R9", "ack held while waiting", {dev_ack, op_ready}, 3);
    op_valid = 1; op_data = 8'hEF; step(); op_valid = 0;
    expect_take('h28, 0, 'hEF, "R9");
    // R10: non-restart byte becomes a call
    gen_req_in = 1; enable(); sample(); gen_req_in = 0;
    op_valid = 1; op_data = 8'hCD; step(); op_valid = 0;
    expect_take(0, 1, 'hCD, "R10");
    // R9: restart 0
    gen_req_in = 1; enable(); sample(); gen_req_in = 0;
    op_valid = 1; op_data = 8'hC7; step(); op_valid = 0;
    expect_take(0, 0, 'hC7, "R9");
    // R11 / R12: strobes during service ignored; held offer stays stable
    nmi_in = 1; sample();
    chk(core_req == 1, "R11", "entry offered", core_req, 1);
    sample(); sample();
    chk(core_req == 1 && core_vec == 'h24, "R12", "offer unchanged", core_vec, 'h24);
    core_accept = 1; step(); core_accept = 0;
    sample(); sample();
    chk(core_req == 0, "R11", "no re-entry while busy", core_req, 0);
    core_done = 1; step(); core_done = 0; step(2);
    chk(core_req == 0, "R11", "idle without boundary", core_req, 0);
    sample(); nmi_in = 0;
    expect_take('h24, 0, 0, "R12", 4);
    step(5);
    report();
  end

endmodule